// File: doc/BRIEF.md
# Nonrestoring Divide-Step Unit

This block divides a 32-bit dividend by a 16-bit divisor, one quotient bit per clock, using conditional add/subtract steps without restoring the partial remainder. The dividend sits in a register pair. The high half is the running partial remainder and the low half collects the quotient. One adder/subtractor serves both step kinds. A status bit carried from step to step selects the adder operation for the next step, and the quotient bit written at each step is the inverse of that status bit.

Two step kinds exist. The sign step runs once at the start of a signed divide. It records the XOR of the operand signs and shifts the register pair left, with the high half passed through the adder unchanged. The quotient step subtracts the divisor from the partial remainder, or adds it back. It reloads the high half with the result shifted one place, pulling in the MSB of the low half, and shifts one quotient bit into the low half. A small controller accepts a start pulse with operands and a signed/unsigned select. It runs sixteen step cycles, pulses done and presents the low register as the quotient.

The quotient carries one more integer bit than the operands imply. An integer divide therefore needs the dividend shifted left by one bit before it is presented, and the caller does this. No final remainder correction is applied.

Top module: `nrdiv_unit`

## Requirements
- R1: After reset, busy, done and zero_err are 0 and quotient is 0.
- R2: A start accepted while busy is 0, with a nonzero divisor, drives busy to 1 from the next cycle for exactly 16 cycles. Done then goes to 1 for exactly one cycle, with busy at 0.
- R3: A start raised while busy is 1 has no effect. The running divide finishes with the same latency and the same quotient as without it.
- R4: With signed_mode 0, the status bit starts at 0 and sixteen quotient steps run. For a divisor D ≤ 16384 and a dividend N whose bits 31:16 are below D, the quotient is floor(N / (2·D)).
- R5: With signed_mode 1 and both operands non-negative, one sign step is followed by fifteen quotient steps. For D ≤ 16384 and bits 31:16 of N below D, the quotient is floor(N / (2·D)).
- R6: With signed_mode 1, bit 15 of the quotient equals dividend bit 31 XOR divisor bit 15.
- R7: With signed_mode 1 and at least one negative operand, with |D| ≤ 16384 and a quotient that fits in 16 signed bits, the quotient read as two's complement lies within one of floor(N / (2·D)).
- R8: For an unsigned integer x presented as dividend x shifted left by one bit, under the R4 limits, the quotient is floor(x / D).
- R9: A start with a divisor of 0, while busy is 0, pulses zero_err for one cycle in the next cycle. It leaves busy and done at 0 and the quotient unchanged.
- R10: While busy is 0 and start is 0, quotient holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide when not busy |
| signed_mode | input | 1 | 1 selects signed operands, 0 unsigned |
| dividend | input | 32 | Dividend, high half becomes the partial remainder |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Step cycles in progress |
| done | output | 1 | One-cycle pulse after the last step |
| zero_err | output | 1 | One-cycle pulse when a start carried a zero divisor |
| quotient | output | 16 | Low register of the pair, quotient after done |

## Verification
The assertions assume that start, signed_mode and the operands change only between clock edges. They also assume that no divide is judged on operands outside the ranges where the step algorithm is valid. The bench therefore keeps every divisor magnitude at or below 16384 and every dividend high half below the divisor, and it applies edge values such as a divisor of exactly 16384. Mixed-sign cases are judged against a one-unit tolerance and not an exact value, because no correction step exists. Operands change only on falling clock edges.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    localparam int unsigned DEF_QW = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_SIGN = 2'd2,
        OP_QUOT = 2'd3
    } step_op_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_ADD  = 2'd1,
        FN_SUB  = 2'd2
    } alu_fn_e;

    // Adder function for a step: quotient steps add when the carried
    // status bit is set and subtract otherwise; other steps pass through.
    function automatic alu_fn_e pick_fn(input step_op_e op, input logic aq);
        alu_fn_e fn;
        if (op == OP_QUOT) begin
            fn = aq ? FN_ADD : FN_SUB;
        end else begin
            fn = FN_PASS;
        end
        return fn;
    endfunction

endpackage

// File: rtl/nrdiv_alu.sv
module nrdiv_alu
    import nrdiv_pkg::*;
#(
    parameter int unsigned DW = DEF_QW
) (
    input  alu_fn_e         fn,
    input  logic [DW-1:0]   rem_in,
    input  logic [DW-1:0]   dvsr_in,
    output logic [DW-1:0]   res
);

    always_comb begin
        unique case (fn)
            FN_ADD:  res = rem_in + dvsr_in;
            FN_SUB:  res = rem_in - dvsr_in;
            default: res = rem_in;
        endcase
    end

endmodule

// File: rtl/nrdiv_regpair.sv
module nrdiv_regpair
    import nrdiv_pkg::*;
#(
    parameter int unsigned DW = DEF_QW
) (
    input  logic              clk,
    input  logic              rst,
    input  step_op_e          op,
    input  logic [2*DW-1:0]   dividend_in,
    input  logic [DW-1:0]     divisor_in,
    output logic [DW-1:0]     low_out
);

    localparam int unsigned MSB = DW - 1;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          aq;
    } pair_t;

    pair_t          cur_q;
    pair_t          nxt;
    logic [DW-1:0]  dvsr_q;
    logic [DW-1:0]  alu_res;
    alu_fn_e        fn;
    logic           aq_new;
    logic           qbit;

    assign fn = pick_fn(op, cur_q.aq);

    nrdiv_alu #(.DW(DW)) u_alu (
        .fn      (fn),
        .rem_in  (cur_q.hi),
        .dvsr_in (dvsr_q),
        .res     (alu_res)
    );

    // Status bit and quotient bit for the two step kinds.
    always_comb begin
        if (op == OP_SIGN) begin
            aq_new = cur_q.hi[MSB] ^ dvsr_q[MSB];
            qbit   = aq_new;
        end else begin
            aq_new = dvsr_q[MSB] ^ alu_res[MSB];
            qbit   = ~aq_new;
        end
    end

    always_comb begin
        nxt = cur_q;
        unique case (op)
            OP_LOAD: begin
                nxt.hi = dividend_in[2*DW-1:DW];
                nxt.lo = dividend_in[DW-1:0];
                nxt.aq = 1'b0;
            end
            OP_SIGN, OP_QUOT: begin
                nxt.hi = {alu_res[DW-2:0], cur_q.lo[MSB]};
                nxt.lo = {cur_q.lo[DW-2:0], qbit};
                nxt.aq = aq_new;
            end
            default: nxt = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            dvsr_q <= '0;
        end else begin
            cur_q <= nxt;
            if (op == OP_LOAD) begin
                dvsr_q <= divisor_in;
            end
        end
    end

    assign low_out = cur_q.lo;

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int unsigned DW = DEF_QW
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     signed_mode,
    input  logic     divisor_zero,
    output step_op_e op,
    output logic     busy,
    output logic     done,
    output logic     zero_err
);

    localparam int unsigned CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DW - 1);

    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic [CNT_W-1:0]  step_q;
    logic              sgn_q;
    logic              err_q;
    logic              idle_like;
    logic              accept;

    assign idle_like = (state_q != ST_RUN);
    assign accept    = idle_like && start && !divisor_zero;

    always_comb begin
        state_d = state_q;
        op      = OP_HOLD;
        unique case (state_q)
            ST_RUN: begin
                op = (step_q == '0 && sgn_q) ? OP_SIGN : OP_QUOT;
                if (step_q == LAST_STEP) begin
                    state_d = ST_DONE;
                end
            end
            default: begin
                if (accept) begin
                    op      = OP_LOAD;
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            sgn_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= idle_like && start && divisor_zero;
            if (accept) begin
                step_q <= '0;
                sgn_q  <= signed_mode;
            end else if (state_q == ST_RUN) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign done     = (state_q == ST_DONE);
    assign zero_err = err_q;

endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit
    import nrdiv_pkg::*;
#(
    parameter int unsigned DW = DEF_QW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              signed_mode,
    input  logic [2*DW-1:0]   dividend,
    input  logic [DW-1:0]     divisor,
    output logic              busy,
    output logic              done,
    output logic              zero_err,
    output logic [DW-1:0]     quotient
);

    step_op_e op;
    logic     divisor_zero;

    assign divisor_zero = (divisor == '0);

    nrdiv_ctrl #(.DW(DW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .signed_mode  (signed_mode),
        .divisor_zero (divisor_zero),
        .op           (op),
        .busy         (busy),
        .done         (done),
        .zero_err     (zero_err)
    );

    nrdiv_regpair #(.DW(DW)) u_pair (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .dividend_in (dividend),
        .divisor_in  (divisor),
        .low_out     (quotient)
    );

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
    parameter int unsigned DW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              signed_mode,
    input logic [2*DW-1:0]   dividend,
    input logic [DW-1:0]     divisor,
    input logic              busy,
    input logic              done,
    input logic              zero_err,
    input logic [DW-1:0]     quotient
);

    localparam int unsigned RUN_W = $clog2(DW + 2) + 1;

    logic [RUN_W-1:0] run_cnt;
    logic             exp_msb;
    logic             sgn_c;
    logic             take;

    assign take = start && !busy && (divisor != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            exp_msb <= 1'b0;
            sgn_c   <= 1'b0;
        end else begin
            if (busy) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
            if (take) begin
                exp_msb <= dividend[2*DW-1] ^ divisor[DW-1];
                sgn_c   <= signed_mode;
            end
        end
    end

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == RUN_W'(DW)));                          // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R2
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));                                           // R2
    AST_RUN_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));                                   // R3
    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
        (done && sgn_c) |-> (quotient[DW-1] == exp_msb));           // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=> (zero_err && !busy && !done)); // R9
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
        zero_err |-> $stable(quotient));                            // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(quotient));                   // R10

endmodule

bind nrdiv_unit nrdiv_checker #(.DW(DW)) u_nrdiv_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .zero_err    (zero_err),
    .quotient    (quotient)
);

// File: tb/nrdiv_unit_bench.sv
module nrdiv_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              signed_mode;
    logic [2*DW-1:0]   dividend;
    logic [DW-1:0]     divisor;
    logic              busy;
    logic              done;
    logic              zero_err;
    logic [DW-1:0]     quotient;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nrdiv_unit #(.DW(DW)) u_nrdiv_unit (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .zero_err    (zero_err),
        .quotient    (quotient)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint floor_div(input longint a, input longint b);
        longint q;
        q = a / b;
        if ((a % b) != 0 && ((a < 0) != (b < 0))) q = q - 1;
        return q;
    endfunction

    // Runs one divide; lat counts falling edges after the accepting edge until done.
    task automatic run_div(input logic [31:0] n, input logic [15:0] d, input logic sg,
                           output logic [15:0] q, output int lat, output bit busy_ok);
        @(negedge clk);
        start = 1'b1; dividend = n; divisor = d; signed_mode = sg;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!done && lat < 40) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (busy) busy_ok = 1'b0;
        q = quotient;
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", longint'(busy), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check(zero_err == 1'b0, "R1 zero_err", longint'(zero_err), 0);
        check(quotient == '0, "R1 quotient", longint'(quotient), 0);
    endtask

    task automatic t_unsigned();
        logic [31:0] ns [4] = '{32'd1000, 32'h1234_5678, 32'h3FFF_FFFF, 32'h0000_FFFF};
        logic [15:0] ds [4] = '{16'd3, 16'h3000, 16'h4000, 16'd1};
        for (int i = 0; i < 4; i++) begin
            logic [15:0] q;
            int lat;
            bit bok;
            longint exp;
            run_div(ns[i], ds[i], 1'b0, q, lat, bok);
            exp = longint'(ns[i]) / (2 * longint'(ds[i]));
            check(longint'(q) == exp, "R4 unsigned quotient", longint'(q), exp);
            check(lat == 17, "R2 latency", longint'(lat), 17);
            check(bok, "R2 busy window", longint'(bok), 1);
            @(negedge clk);
            check(done == 1'b0, "R2 done single cycle", longint'(done), 0);
        end
    endtask

    task automatic t_integer();
        logic [31:0] xs [2] = '{32'd50000, 32'd123456789};
        logic [15:0] ds [2] = '{16'd7, 16'd9999};
        for (int i = 0; i < 2; i++) begin
            logic [15:0] q;
            int lat;
            bit bok;
            longint exp;
            run_div(xs[i] << 1, ds[i], 1'b0, q, lat, bok);
            exp = longint'(xs[i]) / longint'(ds[i]);
            check(longint'(q) == exp, "R8 integer quotient", longint'(q), exp);
        end
    endtask

    task automatic t_signed_pos();
        logic [31:0] ns [2] = '{32'h0123_4567, 32'd1000};
        logic [15:0] ds [2] = '{16'h2000, 16'd5};
        for (int i = 0; i < 2; i++) begin
            logic [15:0] q;
            int lat;
            bit bok;
            longint exp;
            run_div(ns[i], ds[i], 1'b1, q, lat, bok);
            exp = longint'(ns[i]) / (2 * longint'(ds[i]));
            check(longint'(q) == exp, "R5 signed positive quotient", longint'(q), exp);
            check(q[15] == 1'b0, "R6 sign bit positive", longint'(q[15]), 0);
            check(lat == 17, "R2 signed latency", longint'(lat), 17);
        end
    endtask

    task automatic t_signed_mixed();
        logic [31:0] ns [3] = '{-32'sd1000, 32'd100000, -32'sd100000};
        logic [15:0] ds [3] = '{16'd5, -16'sd7, -16'sd7};
        for (int i = 0; i < 3; i++) begin
            logic [15:0] q;
            int lat;
            bit bok;
            longint exp;
            longint act;
            longint diff;
            run_div(ns[i], ds[i], 1'b1, q, lat, bok);
            exp  = floor_div(longint'($signed(ns[i])), 2 * longint'($signed(ds[i])));
            act  = longint'($signed(q));
            diff = act - exp;
            check(diff >= -1 && diff <= 1, "R7 mixed sign quotient", act, exp);
            check(q[15] == (ns[i][31] ^ ds[i][15]), "R6 sign bit",
                  longint'(q[15]), longint'(ns[i][31] ^ ds[i][15]));
        end
    endtask

    task automatic t_start_busy();
        int lat;
        longint exp;
        exp = longint'(32'h0002_0000) / (2 * 11);
        @(negedge clk);
        start = 1'b1; dividend = 32'h0002_0000; divisor = 16'd11; signed_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            if (lat == 5) begin
                start = 1'b1; dividend = 32'h0000_0100; divisor = 16'd3; signed_mode = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == 17, "R3 latency with start while busy", longint'(lat), 17);
        check(longint'(quotient) == exp, "R3 quotient with start while busy",
              longint'(quotient), exp);
    endtask

    task automatic t_zero_and_hold();
        logic [15:0] prev;
        bit saw_done;
        prev = quotient;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
        end
        check(quotient == prev, "R10 idle hold", longint'(quotient), longint'(prev));
        @(negedge clk);
        start = 1'b1; dividend = 32'h0000_1234; divisor = 16'd0; signed_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(zero_err == 1'b1, "R9 zero_err pulse", longint'(zero_err), 1);
        check(busy == 1'b0, "R9 no busy", longint'(busy), 0);
        @(negedge clk);
        check(zero_err == 1'b0, "R9 zero_err single cycle", longint'(zero_err), 0);
        saw_done = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || busy) saw_done = 1'b1;
        end
        check(!saw_done, "R9 no run after zero divisor", longint'(saw_done), 0);
        check(quotient == prev, "R9 quotient unchanged", longint'(quotient), longint'(prev));
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        signed_mode = 1'b0;
        dividend = '0;
        divisor = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_integer();
        t_signed_pos();
        t_signed_mixed();
        t_start_busy();
        t_zero_and_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule